// File: doc/BRIEF.md
# Registered-Output Synchronous FIFO

This block is a single-clock first-in first-out queue whose read data always comes straight from a flip-flop. Incoming words go first into an inner storage queue of `DEPTH-1` entries. That queue feeds a one-entry output register. Whenever the output register is empty or is being read, it reloads itself from the inner queue. A consumer therefore sees fall-through behaviour: the head word is presented on `dout` with `readable` high, without any request. A downstream path never starts from a memory read port.

The block pays for this with one cycle of extra latency. A word written into an empty queue becomes readable exactly two clock edges after it was accepted. The `level` output counts the entries in the inner queue plus the one held in the output register, so the total capacity is `DEPTH`. One read per cycle can be sustained indefinitely.

Top module: `regfifo`

## Requirements
- R1: While `rst` is high and in the first cycle after it is released, `level` is 0, `readable` is low and `writable` is high.
- R2: After each clock edge, `level` equals its previous value, plus 1 if `we` and `writable` were both high, minus 1 if `re` and `readable` were both high.
- R3: `readable` is low whenever `level` is 0 and high whenever `level` is greater than 1.
- R4: When `level` is 1 and the output register held that single entry in the previous cycle, `readable` stays high if and only if that entry was not read.
- R5: A word written into an empty queue is not readable after the first edge. It becomes readable after the second edge, and it is then on `dout`.
- R6: If `re` was low in the previous cycle, `dout` keeps its value. The one exception is a rise of `readable`, when `dout` shows the `din` accepted two edges earlier.
- R7: Words leave in the order they were accepted, with none lost or duplicated. With `re` held high and data available, one word is delivered every cycle.
- R8: `writable` is low exactly when `level` equals `DEPTH`. A write attempted while `writable` is low stores nothing.
- R9: `dout` is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| din | input | WIDTH | Write data |
| we | input | 1 | Write request; accepted when `writable` is high |
| writable | output | 1 | Queue can accept a word this cycle |
| dout | output | WIDTH | Head word, driven from a flip-flop |
| re | input | 1 | Read request; consumes the head when `readable` is high |
| readable | output | 1 | `dout` holds a valid head word |
| level | output | $clog2(DEPTH+1) | Number of stored words, inner queue plus output register |

## Verification
The bench writes into an empty queue and samples after each of the next two edges. A design with a bypass would show the word one cycle early, and one with a second pipeline stage would show it late. It fills the queue to `DEPTH` and pushes an extra marker word that must never come out. A design that signals full one entry early or late would either block a legal write or overwrite stored data. It then streams with reads and writes every cycle, checking that `readable` never drops and `level` stays flat. An output register that reloads only one cycle after being emptied would produce bubbles there. It also reads the sole remaining entry and checks that the queue reports empty at once.

// File: rtl/regfifo.sv
module regfifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  input  logic             we,
  output logic             writable,
  output logic [WIDTH-1:0] dout,
  input  logic             re,
  output logic             readable,
  output logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int IDEPTH = DEPTH - 1;
  localparam int PW = (IDEPTH > 1) ? $clog2(IDEPTH) : 1;
  localparam int CW = $clog2(IDEPTH + 1);
  localparam int LW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [IDEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] icnt;
  logic          ovalid;
  logic          ipush, opop, oload;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(IDEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign level    = LW'(icnt) + LW'(ovalid);
  assign writable = (level != LW'(DEPTH));
  assign readable = ovalid;
  assign ipush    = we && writable;
  assign opop     = re && ovalid;
  assign oload    = (icnt != '0) && (!ovalid || opop);

  always_ff @(posedge clk)
    if (ipush) mem[wptr] <= din;

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr   <= '0;
      rptr   <= '0;
      icnt   <= '0;
      ovalid <= 1'b0;
      dout   <= '0;
    end else begin
      if (ipush) wptr <= bump(wptr);
      if (oload) begin
        rptr <= bump(rptr);
        dout <= mem[rptr];
      end
      icnt   <= icnt + CW'(ipush) - CW'(oload);
      ovalid <= oload || (ovalid && !opop);
    end
  end
endmodule

module regfifo_checker #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] din,
  input logic             we,
  input logic             writable,
  input logic [WIDTH-1:0] dout,
  input logic             re,
  input logic             readable,
  input logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int LW = $clog2(DEPTH + 1);
  logic [1:0] since;

  always_ff @(posedge clk)
    if (rst) since <= '0;
    else if (since != 2'd3) since <= since + 1'b1;

  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    (since == 2'd0) |-> (level == '0 && !readable && writable));

  p_level_step_r2: assert property (@(posedge clk) disable iff (rst)
    (since != 2'd0) |-> (level == LW'($past(level) + LW'($past(we && writable)) - LW'($past(re && readable)))));

  p_empty_low_r3: assert property (@(posedge clk) disable iff (rst)
    (level == '0) |-> !readable);

  p_many_high_r3: assert property (@(posedge clk) disable iff (rst)
    (level > LW'(1)) |-> readable);

  p_sole_entry_r4: assert property (@(posedge clk) disable iff (rst)
    (since != 2'd0 && level == LW'(1) && $past(readable) && $past(level) == LW'(1))
      |-> (readable == !$past(re)));

  p_two_cycle_r5: assert property (@(posedge clk) disable iff (rst)
    (since >= 2'd2 && level == LW'(1) && !$past(readable)) |-> (readable == $past(we, 2)));

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (since != 2'd0 && !$past(re) && !(readable && !$past(readable))) |-> (dout == $past(dout)));

  p_first_word_r6: assert property (@(posedge clk) disable iff (rst)
    (since >= 2'd2 && readable && !$past(readable) && !$past(re)) |-> (dout == $past(din, 2)));

  p_full_r8: assert property (@(posedge clk) disable iff (rst)
    writable == (level != LW'(DEPTH)));
endmodule

bind regfifo regfifo_checker #(.WIDTH(WIDTH), .DEPTH(DEPTH)) chk (.*);

// File: tb/regfifo_test.sv
module regfifo_test;
  localparam int WIDTH = 8;
  localparam int DEPTH = 4;
  localparam int LW = $clog2(DEPTH + 1);

  logic clk = 0;
  logic rst = 1;
  logic [WIDTH-1:0] din = '0;
  logic we = 0, re = 0;
  logic writable, readable;
  logic [WIDTH-1:0] dout;
  logic [LW-1:0] level;

  int runs = 0, fails = 0;
  int exp_lvl = 0;
  logic [WIDTH-1:0] sb [$];
  bit done = 0;

  regfifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .din(din), .we(we), .writable(writable),
    .dout(dout), .re(re), .readable(readable), .level(level));

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // driver: sets inputs after a falling edge, records accepted words
  task automatic step(input bit w, input logic [WIDTH-1:0] d, input bit r);
    @(negedge clk);
    we = w; din = d; re = r;
    #1;
    if (w && writable) sb.push_back(d);
    @(posedge clk);
    #1;
  endtask

  // monitor: pops the scoreboard on every consumed word (R7) and tracks level (R2)
  always @(posedge clk) begin
    if (rst) exp_lvl <= 0;
    else begin
      if (re && readable) begin
        if (sb.size() == 0) check(0, "R7 read from empty scoreboard", int'(dout), -1);
        else check(dout == sb[0], "R7 order", int'(dout), int'(sb[0]));
        if (sb.size() != 0) void'(sb.pop_front());
      end
      exp_lvl <= exp_lvl + int'(we && writable) - int'(re && readable);
    end
  end

  always @(negedge clk)
    if (!rst) check(int'(level) == exp_lvl, "R2 level", int'(level), exp_lvl);

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(level == '0 && !readable && writable, "R1 reset flags", int'(level), 0);
    check(dout == '0, "R9 dout after reset", int'(dout), 0);
    @(negedge clk);
    rst = 0;
    @(posedge clk);
    #1;
    check(level == '0 && !readable && writable, "R1 after release", int'(readable), 0);
    check(!readable, "R3 empty not readable", int'(readable), 0);

    step(1, 8'hA1, 0);
    check(!readable, "R5 not visible after first edge", int'(readable), 0);
    step(0, 8'h00, 0);
    check(readable, "R5 visible after second edge", int'(readable), 1);
    check(dout == 8'hA1, "R6 first word on dout", int'(dout), 'hA1);
    step(0, 8'h00, 0);
    check(dout == 8'hA1 && readable, "R6 dout holds without read", int'(dout), 'hA1);
    check(readable, "R4 sole entry stays when not read", int'(readable), 1);
    step(0, 8'h00, 1);
    check(!readable, "R4 sole entry read leaves queue empty", int'(readable), 0);

    for (int i = 0; i < DEPTH; i++) step(1, 8'hB0 + 8'(i), 0);
    step(0, 8'h00, 0);
    check(int'(level) == DEPTH, "R8 level at capacity", int'(level), DEPTH);
    check(!writable, "R8 writable low when full", int'(writable), 0);
    check(readable, "R3 readable with level above one", int'(readable), 1);
    step(1, 8'hEE, 0);
    check(int'(level) == DEPTH, "R8 write while full ignored", int'(level), DEPTH);
    check(dout == 8'hB0, "R6 head unchanged while full", int'(dout), 'hB0);

    for (int i = 0; i < DEPTH; i++) begin
      check(readable, "R7 back-to-back read available", int'(readable), 1);
      step(0, 8'h00, 1);
    end
    check(!readable && level == '0, "R7 drained", int'(level), 0);

    for (int i = 0; i < 12; i++) begin
      step(1, 8'hC0 + 8'(i), 1);
      if (i >= 1) begin
        check(readable, "R7 streaming keeps readable", int'(readable), 1);
        check(int'(level) == 2, "R2 streaming level flat", int'(level), 2);
      end
    end
    for (int i = 0; i < 4; i++) step(0, 8'h00, 1);
    check(level == '0 && sb.size() == 0, "R7 all words delivered", sb.size(), 0);
    check(writable, "R8 writable when not full", int'(writable), 1);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        check(0, "watchdog expired", 0, 1);
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule